// File: doc/BRIEF.md
# CAN bit timing generator

This block derives the bit-level timing of a CAN node from its module clock. Two byte-wide configuration registers set the quantum prescaler, the resynchronisation jump width, and the lengths of the phase segments on each side of the sample point. They also select single or three-sample majority sampling. From these the block produces a time-quantum enable, a sample strobe with the sampled bus level, and a strobe that marks the first clock of every bit. It also reports which segment of the bit is running.

The registers can only be changed while the controller holds the block in reset mode. Reset mode also parks the timing at the start of the synchronisation segment. After reset mode is released the block waits, with counting idle, until the first recessive-to-dominant transition on the bus. That transition hard-synchronises the first bit. From then on, each falling edge of the bus may stretch or trim the current bit by at most the jump width, once per bit. No such adjustment is made while the node itself drives a dominant level.

Top module: `can_bit_timer`

## Requirements
- R1: After reset both configuration registers read back as zero. A write with `reset_mode` high stores `cfg_wr_data` into register 0 (`cfg_wr_sel`=0) or register 1 (`cfg_wr_sel`=1), and the stored value is visible on `cfg_t0`/`cfg_t1` from the next clock. Register 0 holds the jump width minus one in bits [7:6] and the prescaler value `brpf` in bits [5:0]. Register 1 holds the triple-sampling flag in bit 7, TSEG2 minus one in bits [6:4] and TSEG1 minus one in bits [3:0].
- R2: A write with `reset_mode` low leaves both registers unchanged.
- R3: Once running, `tq_en` is high for exactly one clock in every 2×(`brpf`+1) clocks. That clock is the last one of each quantum.
- R4: A bit lasts (1+TSEG1+TSEG2) quanta. `bit_stb` is high in the first clock of each bit. `sample_stb` is high in the clock after the end of quantum number TSEG1, counting the sync quantum as number 0. `seg` reads 0 in the sync quantum, 1 in the segment before the sample point and 2 after it, and the two strobes never coincide.
- R5: While `reset_mode` is high, `seg` is 0 and no strobe or `tq_en` is produced. After `reset_mode` falls, nothing is produced until the first falling edge of `rx_in`. The clock after that edge starts a new bit and raises `bit_stb`.
- R6: With the triple flag at 0, `rx_bit` takes the level of `rx_in` at the clock edge where the sample point ends.
- R7: With the triple flag at 1, `rx_bit` is the majority of `rx_in` at the ends of quanta TSEG1−2, TSEG1−1 and TSEG1.
- R8: A falling edge inside the pre-sample segment lengthens that segment by the smaller of the jump width and the number of quanta elapsed since the sync quantum. A falling edge inside the sync quantum changes nothing.
- R9: A falling edge after the sample point has a phase error equal to the quanta left in the post-sample segment, counting the current one. If that error exceeds the jump width, the segment is shortened by the jump width. Otherwise a new bit starts on the clock after the edge.
- R10: Only the first qualifying falling edge of a bit adjusts timing. No adjustment is made while `tx_dominant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller reset mode; enables configuration writes and parks the timing |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Register select: 0 = prescaler/jump width, 1 = segments/sampling |
| cfg_wr_data | input | 8 | Configuration write data |
| rx_in | input | 1 | Bus level, synchronous to clk (1 = recessive) |
| tx_dominant | input | 1 | High while this node drives a dominant bit |
| cfg_t0 | output | 8 | Register 0 contents |
| cfg_t1 | output | 8 | Register 1 contents |
| tq_en | output | 1 | Last clock of each time quantum |
| sample_stb | output | 1 | One-clock pulse after the sample point |
| rx_bit | output | 1 | Sampled bus level, updated with sample_stb |
| bit_stb | output | 1 | First clock of each bit |
| seg | output | 2 | Current segment: 0 sync, 1 before sample, 2 after sample |

## Verification
`tq_en` is combinational and sits in the final clock of a quantum. `sample_stb`, `rx_bit` and `bit_stb` are registered on the quantum-ending edge, so they show up one clock later. A hard or resynchronising restart shows `bit_stb` on the clock right after the edge that carries the falling bus level. The bench drives and samples on falling clock edges. It numbers every later falling edge from the first one after the hard-synchronising edge. Each expected strobe position is then a closed-form multiple of the quantum length, plus the resynchronisation offset worked out from the quantum where the edge falls. Register readback is checked one clock after each write.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reset_mode,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_wr_sel,
  input  logic [TS1_W+TS2_W:0] cfg_wr_data,
  input  logic                 rx_in,
  input  logic                 tx_dominant,
  output logic [TS1_W+TS2_W:0] cfg_t0,
  output logic [TS1_W+TS2_W:0] cfg_t1,
  output logic                 tq_en,
  output logic                 sample_stb,
  output logic                 rx_bit,
  output logic                 bit_stb,
  output logic [1:0]           seg
);
  localparam int RW = TS1_W + TS2_W + 1;
  localparam int PW = BRP_W + 1;
  localparam int QW = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;
  localparam logic [1:0] SEG_SYNC = 2'd0;
  localparam logic [1:0] SEG_PRE  = 2'd1;
  localparam logic [1:0] SEG_POST = 2'd2;

  logic [RW-1:0] t0_q, t1_q;
  logic [PW-1:0] pcnt;
  logic [QW-1:0] qcnt, ext, shr;
  logic [1:0]    seg_q, hist;
  logic          idle, resynced, rx_prev, samp_q, bit_q, rxb_q;

  wire [BRP_W-1:0] brpf   = t0_q[BRP_W-1:0];
  wire [SJW_W-1:0] sjwf   = t0_q[BRP_W +: SJW_W];
  wire [TS1_W-1:0] t1f    = t1_q[TS1_W-1:0];
  wire [TS2_W-1:0] t2f    = t1_q[TS1_W +: TS2_W];
  wire             triple = t1_q[RW-1];

  wire [PW-1:0] tq_last = {brpf, 1'b1};
  wire [QW-1:0] sjw     = QW'(sjwf) + QW'(1);
  wire [QW-1:0] t1n     = QW'(t1f) + QW'(1);
  wire [QW-1:0] t2n     = QW'(t2f) + QW'(1);
  wire [QW-1:0] qnext   = qcnt + QW'(1);

  wire tq_end    = (pcnt == tq_last);
  wire fall      = rx_prev & ~rx_in;
  wire hard      = idle & ~reset_mode & fall;
  wire rs_ok     = fall & ~idle & ~reset_mode & ~resynced & ~tx_dominant;
  wire len_now   = rs_ok & (seg_q == SEG_PRE);
  wire short_now = rs_ok & (seg_q == SEG_POST);

  wire [QW-1:0] err_post = t2n - qcnt;
  wire          restart  = short_now & (err_post <= sjw);
  wire [QW-1:0] ext_w    = len_now ? ((qnext < sjw) ? qnext : sjw) : ext;
  wire [QW-1:0] shr_w    = (short_now & ~restart) ? sjw : shr;
  wire [QW-1:0] pre_len  = t1n + ext_w;
  wire [QW-1:0] post_len = t2n - shr_w;

  wire maj  = (hist[1] & hist[0]) | (hist[1] & rx_in) | (hist[0] & rx_in);
  wire vote = triple ? maj : rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_q <= '0;
      t1_q <= '0;
    end else if (cfg_wr_en && reset_mode) begin
      if (cfg_wr_sel) t1_q <= cfg_wr_data;
      else            t0_q <= cfg_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      qcnt     <= '0;
      ext      <= '0;
      shr      <= '0;
      seg_q    <= SEG_SYNC;
      hist     <= '0;
      idle     <= 1'b1;
      resynced <= 1'b0;
      samp_q   <= 1'b0;
      bit_q    <= 1'b0;
      rxb_q    <= 1'b1;
    end else begin
      samp_q <= 1'b0;
      bit_q  <= 1'b0;
      if (reset_mode) begin
        pcnt     <= '0;
        qcnt     <= '0;
        ext      <= '0;
        shr      <= '0;
        seg_q    <= SEG_SYNC;
        idle     <= 1'b1;
        resynced <= 1'b0;
      end else if (hard || restart) begin
        pcnt     <= '0;
        qcnt     <= '0;
        ext      <= '0;
        shr      <= '0;
        seg_q    <= SEG_SYNC;
        idle     <= 1'b0;
        resynced <= 1'b0;
        bit_q    <= 1'b1;
      end else if (!idle) begin
        pcnt <= tq_end ? '0 : pcnt + PW'(1);
        ext  <= ext_w;
        shr  <= shr_w;
        if (len_now || short_now) resynced <= 1'b1;
        if (tq_end) begin
          hist <= {hist[0], rx_in};
          case (seg_q)
            SEG_SYNC: begin
              seg_q <= SEG_PRE;
              qcnt  <= '0;
            end
            SEG_PRE: begin
              if (qnext >= pre_len) begin
                seg_q  <= SEG_POST;
                qcnt   <= '0;
                samp_q <= 1'b1;
                rxb_q  <= vote;
              end else begin
                qcnt <= qnext;
              end
            end
            default: begin
              if (qnext >= post_len) begin
                seg_q    <= SEG_SYNC;
                qcnt     <= '0;
                ext      <= '0;
                shr      <= '0;
                resynced <= 1'b0;
                bit_q    <= 1'b1;
              end else begin
                qcnt <= qnext;
              end
            end
          endcase
        end
      end
    end
  end

  assign cfg_t0     = t0_q;
  assign cfg_t1     = t1_q;
  assign tq_en      = tq_end & ~idle & ~reset_mode;
  assign sample_stb = samp_q;
  assign rx_bit     = rxb_q;
  assign bit_stb    = bit_q;
  assign seg        = seg_q;
endmodule

module can_bit_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reset_mode,
  input logic         cfg_wr_en,
  input logic         rx_in,
  input logic [W-1:0] cfg_t0,
  input logic [W-1:0] cfg_t1,
  input logic         tq_en,
  input logic         sample_stb,
  input logic         rx_bit,
  input logic         bit_stb,
  input logic [1:0]   seg
);
  // R2
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && reset_mode) |=> ($stable(cfg_t0) && $stable(cfg_t1)));

  // R3
  tq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tq_en |=> !tq_en);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb));

  // R4
  sample_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (seg == 2'd2));

  // R4
  bit_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (seg == 2'd0));

  // R5
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> (seg == 2'd0 && !bit_stb && !sample_stb && !tq_en));

  // R6
  single_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !cfg_t1[W-1]) |-> (rx_bit == $past(rx_in)));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reset_mode (reset_mode),
  .cfg_wr_en  (cfg_wr_en),
  .rx_in      (rx_in),
  .cfg_t0     (cfg_t0),
  .cfg_t1     (cfg_t1),
  .tq_en      (tq_en),
  .sample_stb (sample_stb),
  .rx_bit     (rx_bit),
  .bit_stb    (bit_stb),
  .seg        (seg)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_mode = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic       cfg_wr_sel = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic       rx_in = 1'b1;
  logic       tx_dominant = 1'b0;
  logic [7:0] cfg_t0, cfg_t1;
  logic       tq_en, sample_stb, rx_bit, bit_stb;
  logic [1:0] seg;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .rx_in(rx_in), .tx_dominant(tx_dominant),
    .cfg_t0(cfg_t0), .cfg_t1(cfg_t1), .tq_en(tq_en), .sample_stb(sample_stb),
    .rx_bit(rx_bit), .bit_stb(bit_stb), .seg(seg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [7:0] d);
    cfg_wr_sel  = sel;
    cfg_wr_data = d;
    cfg_wr_en   = 1'b1;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic park();
    reset_mode = 1'b1;
    rx_in = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unpark();
    reset_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input int brpf, input int sjwf, input int t1f, input int t2f, input bit trip);
    logic [7:0] d0, d1;
    d0 = 8'((sjwf << 6) | brpf);
    d1 = 8'((int'(trip) << 7) | (t2f << 4) | t1f);
    park();
    cfg_write(1'b0, d0);
    cfg_write(1'b1, d1);
    // R1 readback one clock after each write
    check(cfg_t0 == d0 && cfg_t1 == d1, "R1", "register readback",
          int'({cfg_t0, cfg_t1}), int'({d0, d1}));
    unpark();
  endtask

  task automatic sweep_one(input int brpf, input int t1f, input int t2f, input int sjwf);
    int q, t1, n, sp, bad3, bad4;
    setup(brpf, sjwf, t1f, t2f, 1'b0);
    q  = 2 * (brpf + 1);
    t1 = t1f + 1;
    n  = (3 + t1f + t2f) * q;
    sp = (t1 + 1) * q;
    bad3 = 0;
    bad4 = 0;
    rx_in = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2 * n; m++) begin
      if (tq_en !== ((m % q) == q - 1)) bad3++;
      if (bit_stb !== ((m % n) == 0)) bad4++;
      if (sample_stb !== ((m % n) == sp)) bad4++;
      if ((m % n) == 0 && seg !== 2'd0) bad4++;
      if ((m % n) == q && seg !== 2'd1) bad4++;
      if ((m % n) == sp && (seg !== 2'd2 || rx_bit !== 1'b0)) bad4++;
      @(negedge clk);
    end
    check(bad3 == 0, "R3", $sformatf("quantum enable brp=%0d t1=%0d t2=%0d", brpf, t1f, t2f), bad3, 0);
    check(bad4 == 0, "R4", $sformatf("bit timing brp=%0d t1=%0d t2=%0d", brpf, t1f, t2f), bad4, 0);
  endtask

  task automatic run_case(input int ra, input int fa, input int rb, input int fb, input int len,
                          output int s1, output int s2, output int b1, output int v1);
    s1 = -1; s2 = -1; b1 = -1; v1 = -1;
    rx_in = 1'b0;
    @(negedge clk);
    for (int m = 0; m < len; m++) begin
      if (sample_stb) begin
        if (s1 < 0) begin
          s1 = m;
          v1 = int'(rx_bit);
        end else if (s2 < 0) begin
          s2 = m;
        end
      end
      if (bit_stb && m > 0 && b1 < 0) b1 = m;
      if (m == ra || m == rb) rx_in = 1'b1;
      if (m == fa || m == fb) rx_in = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    int s1, s2, b1, v1, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_t0 == 8'h00 && cfg_t1 == 8'h00, "R1", "reset register value", int'({cfg_t0, cfg_t1}), 0);
    check(!tq_en && !sample_stb && !bit_stb && seg == 2'd0, "R5", "reset outputs",
          int'({tq_en, sample_stb, bit_stb, seg}), 0);

    bad = 0;
    for (int i = 0; i < 12; i++) begin
      rx_in = i[0];
      @(negedge clk);
      if (tq_en || bit_stb || sample_stb || seg != 2'd0) bad++;
    end
    check(bad == 0, "R5", "edges ignored in reset mode", bad, 0);

    setup(1, 1, 7, 3, 1'b0);
    cfg_write(1'b0, 8'hFF);
    cfg_write(1'b1, 8'hFF);
    check(cfg_t0 == 8'h41 && cfg_t1 == 8'h37, "R2", "writes outside reset mode",
          int'({cfg_t0, cfg_t1}), int'(16'h4137));

    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tq_en || bit_stb || sample_stb) bad++;
    end
    check(bad == 0, "R5", "idle before hard sync", bad, 0);
    rx_in = 1'b0;
    @(negedge clk);
    check(bit_stb && seg == 2'd0, "R5", "hard sync bit start", int'({bit_stb, seg}), 4);

    // quantum 4 clocks, TSEG1 8, TSEG2 4, jump width 2, 52 clocks per bit
    park(); unpark();
    run_case(1, 5, -1, -1, 70, s1, s2, b1, v1);
    check(s1 == 40 && b1 == 56, "R8", "lengthen by one quantum", s1 * 1000 + b1, 40056);

    park(); unpark();
    run_case(1, 21, -1, -1, 70, s1, s2, b1, v1);
    check(s1 == 44 && b1 == 60, "R8", "lengthen clipped to jump width", s1 * 1000 + b1, 44060);

    park(); unpark();
    run_case(30, 53, -1, -1, 110, s1, s2, b1, v1);
    check(s1 == 36 && b1 == 52 && s2 == 88, "R8", "edge in sync quantum", s2 * 1000 + b1, 88052);
    check(v1 == 1, "R6", "single sample high", v1, 1);

    park(); unpark();
    run_case(1, 37, -1, -1, 70, s1, s2, b1, v1);
    check(s1 == 36 && b1 == 44, "R9", "shorten clipped to jump width", s1 * 1000 + b1, 36044);

    park(); unpark();
    run_case(1, 45, -1, -1, 100, s1, s2, b1, v1);
    check(b1 == 46 && s2 == 82, "R9", "immediate new bit", b1 * 1000 + s2, 46082);

    park(); unpark();
    run_case(1, 5, 6, 13, 70, s1, s2, b1, v1);
    check(s1 == 40 && b1 == 56, "R10", "second edge in bit ignored", s1 * 1000 + b1, 40056);

    park(); unpark();
    tx_dominant = 1'b1;
    run_case(1, 21, -1, -1, 70, s1, s2, b1, v1);
    check(s1 == 36 && b1 == 52, "R10", "no resync while driving dominant", s1 * 1000 + b1, 36052);

    for (int trip = 0; trip < 2; trip++) begin
      int ra_t[4];
      int fa_t[4];
      int es[4];
      int et[4];
      ra_t = '{32, 28, 24, 28};
      fa_t = '{36, 36, 32, 32};
      es   = '{1, 1, 0, 0};
      et   = '{0, 1, 1, 0};
      for (int p = 0; p < 4; p++) begin
        park();
        cfg_write(1'b1, 8'((trip << 7) | 8'h37));
        unpark();
        run_case(ra_t[p], fa_t[p], -1, -1, 40, s1, s2, b1, v1);
        if (trip == 0)
          check(s1 == 36 && v1 == es[p], "R6", $sformatf("single sample pattern %0d", p), v1, es[p]);
        else
          check(s1 == 36 && v1 == et[p], "R7", $sformatf("majority pattern %0d", p), v1, et[p]);
      end
    end
    tx_dominant = 1'b0;

    for (int brpf = 0; brpf < 4; brpf++) begin
      if (brpf == 2) continue;
      for (int t1f = 0; t1f < 16; t1f++) begin
        for (int t2f = 0; t2f < 8; t2f++) begin
          sweep_one(brpf, t1f, t2f, t2f % 4);
        end
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule